// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge Interface

This block sits between an arbiter that reports which interrupt IDs are pending (each with an 8-bit priority) and a single processor. It owns a small register set. Through it, software can:

- enable or disable interrupt delivery,
- program a priority threshold,
- claim the most urgent qualifying interrupt,
- observe that interrupt without claiming it,
- read the current running priority,
- retire a claimed interrupt.

Priorities follow the rule that a smaller value is more urgent. Only the upper four bits of every priority are significant.

A claimed interrupt becomes active. It is not offered again until software writes its ID back to the retire register. Several interrupts may be active at once, nested by priority. The running priority is the most urgent priority among the active set. A further interrupt must be strictly more urgent than both the threshold and the running priority before it raises the request line.

Register offsets on `reg_addr_i` are as follows:

| Offset | Register | Access |
|--------|----------|--------|
| 0 | Control; bit 0 is the enable | read/write |
| 1 | Threshold | read/write |
| 2 | Claim | read |
| 3 | Retire | write |
| 4 | Running priority | read |
| 5 | Peek | read |

Top module: `irq_cpu_iface`

## Requirements
- R1: After reset, `irq_o` is 0, `run_prio_o` is 0xFF, and the control and threshold registers both read 0.
- R2: Threshold bits [7:4] are writable and bits [3:0] always read 0. Writing 0xFF to offset 1 reads back 0xF0.
- R3: A pending, non-active ID qualifies only if its priority, with bits [3:0] cleared, is strictly below the threshold.
- R4: Among qualifying IDs, the smallest masked priority wins. On a tie, the lowest ID wins.
- R5: A read of offset 2 returns the winning ID in bits [9:0], with upper bits 0, and makes that ID active. An active ID is not offered again while it stays active, even if it remains pending.
- R6: When nothing qualifies, a read of offset 2 or offset 5 returns 1023, and no state changes.
- R7: Writing an active ID (in bits [9:0]) to offset 3 clears it from the active set.
- R8: Writing an ID that is not active to offset 3 changes nothing.
- R9: `run_prio_o` equals the smallest masked priority among active IDs, or 0xFF when none is active. A candidate qualifies only if it is also strictly below `run_prio_o`.
- R10: When control bit 0 is 0, `irq_o` stays 0 and a claim read returns 1023. When bit 0 is 1, a qualifying interrupt drives `irq_o` to 1.
- R11: A read of offset 5 returns the same ID a claim would return, without changing the active set or the running priority.
- R12: A read strobe yields `rd_valid_o` = 1 with data on the next cycle, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | NUM_IDS | Pending flag per interrupt ID |
| prio_i | input | NUM_IDS*8 | Priority per ID, ID n in bits [8n+7:8n] |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after strobe |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |
| run_prio_o | output | 8 | Running priority |

## Verification
The assertions check several properties on every cycle:

- The request line never rises for a candidate that fails to beat both the threshold and the running priority.
- The arbiter's winner is always a genuine candidate.
- A claim always leaves its ID active.
- A retire naming an inactive ID leaves the active set untouched.
- Read data is returned on the next cycle.

Only the directed scenarios can show the value-level behaviour: the exact IDs returned under tie-breaking, nested claim and retire sequences and their effect on the running priority, the masking of the low priority bits, and the enable bit's effect on claims.

// File: rtl/irq_cpu_iface_pkg.sv
// Package: shared constants and register offsets for the interrupt CPU interface.
// Assumes the ID field is 10 bits and that fewer than 1023 IDs are implemented.
package irq_cpu_iface_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [2:0] {
        OFS_CTRL  = 3'd0,
        OFS_THRSH = 3'd1,
        OFS_CLAIM = 3'd2,
        OFS_DONE  = 3'd3,
        OFS_RUN   = 3'd4,
        OFS_PEEK  = 3'd5
    } reg_ofs_e;
endpackage

// File: rtl/irq_best_pick.sv
// Module: combinational search for the most urgent candidate ID.
// Assumes priorities are packed PW bits per ID. Only the top IMPL bits count.
// A candidate wins only if its masked priority is strictly below limit_i.
// Ties go to the lowest ID.
module irq_best_pick #(
    parameter int NUM_IDS = 32,
    parameter int PW      = 8,
    parameter int IMPL    = 4,
    localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
    input  logic [NUM_IDS-1:0]    cand_i,
    input  logic [NUM_IDS*PW-1:0] prio_i,
    input  logic [PW-1:0]         limit_i,
    output logic                  found_o,
    output logic [IDX_W-1:0]      id_o,
    output logic [PW-1:0]         prio_o
);
    localparam logic [PW-1:0] KEEP = {{IMPL{1'b1}}, {(PW-IMPL){1'b0}}};

    logic [PW-1:0] eff;

    // Linear scan; strict compare keeps the lowest ID on equal priority.
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        prio_o  = limit_i;
        eff     = '0;
        for (int i = 0; i < NUM_IDS; i++) begin
            eff = prio_i[i*PW +: PW] & KEEP;
            if (cand_i[i] && (eff < prio_o)) begin
                found_o = 1'b1;
                id_o    = IDX_W'(i);
                prio_o  = eff;
            end
        end
    end
endmodule

// File: rtl/irq_active_set.sv
// Module: tracks which IDs are active and the priority each held when claimed.
// Derives the running priority as the smallest stored priority, or all ones
// when the set is empty. Assumes at most one set and one clear per cycle.
module irq_active_set #(
    parameter int NUM_IDS = 32,
    parameter int PW      = 8,
    parameter int IMPL    = 4,
    localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  logic [IDX_W-1:0]   set_id_i,
    input  logic [PW-1:0]      set_prio_i,
    input  logic               clr_i,
    input  logic [IDX_W-1:0]   clr_id_i,
    output logic [NUM_IDS-1:0] act_o,
    output logic [PW-1:0]      run_o
);
    logic [IMPL-1:0] slot_prio [NUM_IDS];

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
        // Per-ID active flag and its captured priority; a claim wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_o[g]     <= 1'b0;
                slot_prio[g] <= '1;
            end else if (set_i && (set_id_i == IDX_W'(g))) begin
                act_o[g]     <= 1'b1;
                slot_prio[g] <= set_prio_i[PW-1 -: IMPL];
            end else if (clr_i && (clr_id_i == IDX_W'(g))) begin
                act_o[g]     <= 1'b0;
            end
        end
    end

    // Minimum captured priority across active slots.
    always_comb begin
        run_o = '1;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (act_o[i] && ({slot_prio[i], {(PW-IMPL){1'b0}}} < run_o)) begin
                run_o = {slot_prio[i], {(PW-IMPL){1'b0}}};
            end
        end
    end
endmodule

// File: rtl/irq_cpu_iface.sv
// Module: per-processor interrupt interface top.
// Holds the control and threshold registers and answers register reads one
// cycle after the strobe. Claims and retires go to the active set.
// Assumes pend_i and prio_i are stable, synchronous inputs from the arbiter.
module irq_cpu_iface
    import irq_cpu_iface_pkg::*;
#(
    parameter int NUM_IDS = 32,
    parameter int PW      = 8,
    parameter int IMPL    = 4,
    localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IDS-1:0]    pend_i,
    input  logic [NUM_IDS*PW-1:0] prio_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_wr_i,
    input  logic [2:0]            reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic                  rd_valid_o,
    output logic [31:0]           rd_data_o,
    output logic                  irq_o,
    output logic [PW-1:0]         run_prio_o
);
    logic            en_q;
    logic [IMPL-1:0] thr_q;
    logic [PW-1:0]   thr_full;
    logic [PW-1:0]   limit;
    logic [NUM_IDS-1:0] act_vec;
    logic [NUM_IDS-1:0] cand;
    logic            found;
    logic [IDX_W-1:0] best_id;
    logic [PW-1:0]   best_prio;
    logic            qual;
    logic [ID_W-1:0] offer_id;
    logic            claim_fire;
    logic            done_wr;
    logic [ID_W-1:0] done_id;
    logic            done_hit;
    logic [31:0]     rd_mux;

    assign thr_full = {thr_q, {(PW-IMPL){1'b0}}};
    assign limit    = (thr_full < run_prio_o) ? thr_full : run_prio_o;
    assign cand     = pend_i & ~act_vec;

    irq_best_pick #(.NUM_IDS(NUM_IDS), .PW(PW), .IMPL(IMPL)) pick_i (
        .cand_i  (cand),
        .prio_i  (prio_i),
        .limit_i (limit),
        .found_o (found),
        .id_o    (best_id),
        .prio_o  (best_prio)
    );

    assign qual       = en_q && found;
    assign irq_o      = qual;
    assign offer_id   = qual ? ID_W'(best_id) : SPURIOUS_ID;
    assign claim_fire = reg_rd_i && (reg_addr_i == OFS_CLAIM) && qual;
    assign done_wr    = reg_wr_i && (reg_addr_i == OFS_DONE);
    assign done_id    = reg_wdata_i[ID_W-1:0];
    assign done_hit   = done_wr && (int'(done_id) < NUM_IDS) && act_vec[done_id[IDX_W-1:0]];

    irq_active_set #(.NUM_IDS(NUM_IDS), .PW(PW), .IMPL(IMPL)) act_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (claim_fire),
        .set_id_i   (best_id),
        .set_prio_i (best_prio),
        .clr_i      (done_hit),
        .clr_id_i   (done_id[IDX_W-1:0]),
        .act_o      (act_vec),
        .run_o      (run_prio_o)
    );

    // Control and threshold register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            thr_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == OFS_CTRL)  en_q  <= reg_wdata_i[0];
            if (reg_addr_i == OFS_THRSH) thr_q <= reg_wdata_i[PW-1 -: IMPL];
        end
    end

    // Read data selection by offset.
    always_comb begin
        unique case (reg_addr_i)
            OFS_CTRL:             rd_mux = {31'b0, en_q};
            OFS_THRSH:            rd_mux = 32'(thr_full);
            OFS_CLAIM, OFS_PEEK:  rd_mux = 32'(offer_id);
            OFS_RUN:              rd_mux = 32'(run_prio_o);
            default:              rd_mux = '0;
        endcase
    end

    // Registered read response, valid for one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= reg_rd_i;
            if (reg_rd_i) rd_data_o <= rd_mux;
        end
    end

    // R3
    irq_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (best_prio < thr_full));
    // R9
    irq_below_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (best_prio < run_prio_o));
    // R4
    winner_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[best_id]);
    // R5
    claim_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> act_vec[$past(best_id)]);
    // R8
    stray_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_wr && !done_hit && !claim_fire) |=> $stable(act_vec));
    // R12
    rd_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i |=> rd_valid_o);
    // R12
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> !rd_valid_o);
endmodule

// File: tb/irq_cpu_iface_tb_top.sv
`timescale 1ns/1ps
module irq_cpu_iface_tb_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend = '0;
    logic [N*8-1:0] prio = '1;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          irq;
    logic [7:0]    run_prio;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_cpu_iface #(.NUM_IDS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio),
        .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .irq_o(irq), .run_prio_o(run_prio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R12 rd_valid", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic src(input int id, input logic [7:0] p, input logic on);
        @(negedge clk);
        prio[id*8 +: 8] = p;
        pend[id] = on;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 run", {24'b0, run_prio}, 32'hFF);
        rd(3'd0, d); check("R1 ctrl", d, 0);
        rd(3'd1, d); check("R1 thr", d, 0);
        rd(3'd2, d); check("R6 empty claim", d, 1023);
        @(negedge clk);
        check("R12 single pulse", {31'b0, rd_valid}, 0);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        wr(3'd1, 32'hFF); rd(3'd1, d); check("R2 thr ff", d, 32'hF0);
        wr(3'd1, 32'h5A); rd(3'd1, d); check("R2 thr 5a", d, 32'h50);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(3'd1, 32'hF0);
        src(4, 8'h40, 1'b1);
        check("R10 disabled irq", {31'b0, irq}, 0);
        rd(3'd2, d); check("R10 disabled claim", d, 1023);
        check("R6 no state change", {24'b0, run_prio}, 32'hFF);
        wr(3'd0, 32'h1);
        check("R10 enabled irq", {31'b0, irq}, 1);
        src(4, 8'h40, 1'b0);
    endtask

    task automatic t_qualify();
        src(5, 8'h37, 1'b1);
        wr(3'd1, 32'h30);
        check("R3 equal not below", {31'b0, irq}, 0);
        wr(3'd1, 32'h40);
        check("R3 below", {31'b0, irq}, 1);
        src(5, 8'h3F, 1'b1);
        check("R3 low bits ignored", {31'b0, irq}, 1);
        src(5, 8'h4F, 1'b1);
        check("R3 masked 0x40 not below", {31'b0, irq}, 0);
        src(5, 8'hFF, 1'b0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        wr(3'd1, 32'hF0);
        src(3, 8'h80, 1'b1);
        src(9, 8'h20, 1'b1);
        src(7, 8'h2C, 1'b1);
        rd(3'd5, d); check("R4 tie lowest id", d, 7);
        rd(3'd5, d); check("R11 peek repeat", d, 7);
        check("R11 run unchanged", {24'b0, run_prio}, 32'hFF);
        rd(3'd2, d); check("R5 claim id", d, 7);
        check("R9 run after claim", {24'b0, run_prio}, 32'h20);
        check("R9 equal run blocks", {31'b0, irq}, 0);
        rd(3'd2, d); check("R5 active not offered", d, 1023);
        wr(3'd3, 32'd3);
        check("R8 stray id3", {24'b0, run_prio}, 32'h20);
        wr(3'd3, 32'd9);
        check("R8 stray id9", {24'b0, run_prio}, 32'h20);
        wr(3'd3, 32'd7);
        check("R7 retire", {24'b0, run_prio}, 32'hFF);
        rd(3'd5, d); check("R7 re-offered", d, 7);
        src(7, 8'hFF, 1'b0);
        src(9, 8'hFF, 1'b0);
        src(3, 8'hFF, 1'b0);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        src(3, 8'h80, 1'b1);
        rd(3'd2, d); check("R5 claim low", d, 3);
        check("R9 run 80", {24'b0, run_prio}, 32'h80);
        src(3, 8'h80, 1'b0);
        src(9, 8'h20, 1'b1);
        check("R9 nested irq", {31'b0, irq}, 1);
        rd(3'd2, d); check("R5 claim nested", d, 9);
        check("R9 run 20", {24'b0, run_prio}, 32'h20);
        rd(3'd4, d); check("R9 run reg", d, 32'h20);
        src(9, 8'h20, 1'b0);
        wr(3'd3, 32'd9);
        check("R7 back to 80", {24'b0, run_prio}, 32'h80);
        wr(3'd3, 32'd3);
        check("R7 empty", {24'b0, run_prio}, 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresh();
        t_enable();
        t_qualify();
        t_order();
        t_nest();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule